// File: doc/BRIEF.md
# Entropy Bit Collection Buffer

This block gathers raw random bits from an external entropy source into a small bank of 32-bit words that software reads over a simple register port. The source presents one bit at a time together with a valid strobe. An internal pacer, set through a divider register, produces a single-cycle sampling tick. On each tick where the generator is enabled, the source bit is valid and bits are still owed, the block stores that bit. Software uses the even divider to keep the sampling rate at or below 500 kHz.

Software enables the generator and programs the divider. It then writes the number of bits it wants, which is eight times the byte count, into the request register. The request register counts down once for each stored bit. Software polls it until it reads zero, and then reads up to eight data words. A post-processing control register is provided for software. It keeps whatever is written to it, but the bits always reach the buffer unprocessed.

Top module: `entropy_fifo_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0, and the generator is disabled.
- R2: The divider register at offset 0x00 keeps bits 15:0 of a write, and its upper bits read 0. With a value D of 2 or more, sampling ticks come exactly D clock cycles apart.
- R3: A divider value of 0 or 1 gives a tick every 2 cycles, and two ticks never fall in adjacent cycles.
- R4: The control register at offset 0x20 keeps only bit 31, the generator enable, and the other bits read 0. While bit 31 is clear, no bit is stored and the remaining count holds.
- R5: The post-processing register at offset 0x30 reads back the full 32-bit value last written. Its value has no effect on the stored bits.
- R6: Writing the request register at offset 0x50 sets the remaining count to the written value, clamped to 256. Reading it returns the remaining count.
- R7: A tick with the valid strobe high and a nonzero count stores one bit and lowers the count by exactly 1. A tick with the strobe low stores nothing.
- R8: Stored bit k of a request lands in data word k/32 at bit position k%32. Data word w reads at offset 0x80+4*w for w = 0..7.
- R9: Any write to the request register clears all data words and restarts storage at bit 0. If that write falls in the same cycle as a sampling tick, the write wins and the sampled bit is discarded.
- R10: The data words and all unmapped or misaligned addresses ignore writes, and unmapped or misaligned addresses read 0.
- R11: Once the count is 0, sampling stops and the data words keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, captured on the rising edge |
| reg_addr | input | 8 | Byte address for a read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| src_bit | input | 1 | Raw entropy bit |
| src_valid | input | 1 | High when src_bit holds a usable bit |

## Verification
A software write to the request register and a sampling tick can fall in the same clock edge. The two then compete for the count, the write pointer and the data words. The bench first finds the tick phase by watching for a decrement of the count. It then counts one divider period forward and issues the request write on exactly the edge of the next tick, with the source bit held at 1. The collision is judged correct only if three things hold: the count reads back the newly written value with nothing subtracted, word 0 reads 0, and the next stored bit lands at bit 0.

// File: rtl/efc_pkg.sv
package efc_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned DIV_W      = 16;
    localparam int unsigned FIFO_WORDS = 8;

    localparam logic [31:0] OFS_DIV  = 32'h00;
    localparam logic [31:0] OFS_CTRL = 32'h20;
    localparam logic [31:0] OFS_POST = 32'h30;
    localparam logic [31:0] OFS_REQ  = 32'h50;
    localparam logic [31:0] OFS_DATA = 32'h80;

    localparam int unsigned EN_BIT = 31;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIV,
        SEL_CTRL,
        SEL_POST,
        SEL_REQ,
        SEL_DATA
    } reg_sel_e;

    // One qualified sampling event handed from the pacer side to the store.
    typedef struct packed {
        logic fire;
        logic val;
    } sample_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a, input int unsigned words);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            if (a == OFS_DIV)       s = SEL_DIV;
            else if (a == OFS_CTRL) s = SEL_CTRL;
            else if (a == OFS_POST) s = SEL_POST;
            else if (a == OFS_REQ)  s = SEL_REQ;
            else if (a >= OFS_DATA && a < OFS_DATA + 32'(4 * words)) s = SEL_DATA;
        end
        return s;
    endfunction

    function automatic logic [31:0] clamp_count(input logic [31:0] v, input int unsigned cap);
        return (v > 32'(cap)) ? 32'(cap) : v;
    endfunction

endpackage

// File: rtl/efc_pacer.sv
module efc_pacer
    import efc_pkg::*;
#(
    parameter int unsigned DIV_LEN = DIV_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gen_en,
    input  logic [DIV_LEN-1:0] div_val,
    output logic               tick
);
    logic [DIV_LEN-1:0] cnt;
    logic [DIV_LEN-1:0] lim;

    // Values below 2 fall back to a divide-by-2.
    always_comb begin
        if (div_val < DIV_LEN'(2)) lim = DIV_LEN'(1);
        else                       lim = div_val - DIV_LEN'(1);
    end

    // >= keeps the pacer sane if the divider shrinks mid-count.
    assign tick = gen_en && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !gen_en) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + DIV_LEN'(1);
    end
endmodule

// File: rtl/efc_collector.sv
module efc_collector
    import efc_pkg::*;
#(
    parameter int unsigned WLEN   = WORD_W,
    parameter int unsigned NWORDS = FIFO_WORDS,
    localparam int unsigned CAP   = WLEN * NWORDS,
    localparam int unsigned CNT_W = $clog2(CAP + 1),
    localparam int unsigned PTR_W = $clog2(CAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_load,
    input  logic [CNT_W-1:0] req_count,
    input  sample_t          smp,
    output logic [CNT_W-1:0] remain,
    output logic [CAP-1:0]   bank
);
    logic [PTR_W-1:0] ptr;
    logic             take;

    assign take = smp.fire && (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            ptr    <= '0;
            bank   <= '0;
        end else if (req_load) begin
            // A request write has priority over a coincident sample.
            remain <= req_count;
            ptr    <= '0;
            bank   <= '0;
        end else if (take) begin
            bank[ptr] <= smp.val;
            ptr       <= ptr + PTR_W'(1);
            remain    <= remain - CNT_W'(1);
        end
    end
endmodule

// File: rtl/efc_regs.sv
module efc_regs
    import efc_pkg::*;
#(
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned WLEN   = WORD_W,
    parameter int unsigned DIV_LEN = DIV_W,
    parameter int unsigned NWORDS = FIFO_WORDS,
    localparam int unsigned CAP   = WLEN * NWORDS,
    localparam int unsigned CNT_W = $clog2(CAP + 1),
    localparam int unsigned IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [WLEN-1:0]    reg_wdata,
    output logic [WLEN-1:0]    reg_rdata,
    output logic [DIV_LEN-1:0] div_val,
    output logic               gen_en,
    output logic               req_load,
    output logic [CNT_W-1:0]   req_count,
    input  logic [CNT_W-1:0]   remain,
    input  logic [CAP-1:0]     bank
);
    reg_sel_e         sel;
    logic [WLEN-1:0]  post_q;
    logic [IDX_W-1:0] widx;
    logic [31:0]      clamped;

    assign sel       = decode_addr(32'(reg_addr), NWORDS);
    assign widx      = reg_addr[IDX_W+1:2];
    assign clamped   = clamp_count(32'(reg_wdata), CAP);
    assign req_load  = reg_wr && (sel == SEL_REQ);
    assign req_count = clamped[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_val <= '0;
            gen_en  <= 1'b0;
            post_q  <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_DIV:  div_val <= reg_wdata[DIV_LEN-1:0];
                SEL_CTRL: gen_en  <= reg_wdata[EN_BIT];
                SEL_POST: post_q  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_DIV:  reg_rdata = WLEN'(div_val);
            SEL_CTRL: reg_rdata[EN_BIT] = gen_en;
            SEL_POST: reg_rdata = post_q;
            SEL_REQ:  reg_rdata = WLEN'(remain);
            SEL_DATA: reg_rdata = bank[widx*WLEN +: WLEN];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/entropy_fifo_ctrl.sv
module entropy_fifo_ctrl
    import efc_pkg::*;
#(
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned WLEN    = WORD_W,
    parameter int unsigned DIV_LEN = DIV_W,
    parameter int unsigned NWORDS  = FIFO_WORDS,
    localparam int unsigned CAP    = WLEN * NWORDS,
    localparam int unsigned CNT_W  = $clog2(CAP + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [WLEN-1:0] reg_wdata,
    output logic [WLEN-1:0] reg_rdata,
    input  logic            src_bit,
    input  logic            src_valid
);
    logic [DIV_LEN-1:0] div_val;
    logic               gen_en;
    logic               req_load;
    logic [CNT_W-1:0]   req_count;
    logic [CNT_W-1:0]   remain;
    logic [CAP-1:0]     bank;
    logic               smp_tick;
    sample_t            smp;

    assign smp.fire = smp_tick && src_valid;
    assign smp.val  = src_bit;

    efc_regs #(
        .AW(AW), .WLEN(WLEN), .DIV_LEN(DIV_LEN), .NWORDS(NWORDS)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .div_val(div_val), .gen_en(gen_en),
        .req_load(req_load), .req_count(req_count),
        .remain(remain), .bank(bank)
    );

    efc_pacer #(
        .DIV_LEN(DIV_LEN)
    ) u_pacer (
        .clk(clk), .rst(rst),
        .gen_en(gen_en), .div_val(div_val),
        .tick(smp_tick)
    );

    efc_collector #(
        .WLEN(WLEN), .NWORDS(NWORDS)
    ) u_coll (
        .clk(clk), .rst(rst),
        .req_load(req_load), .req_count(req_count),
        .smp(smp), .remain(remain), .bank(bank)
    );
endmodule

// File: rtl/efc_checker.sv
module efc_checker
    import efc_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned CAP   = WORD_W * FIFO_WORDS,
    localparam int unsigned CNT_W = $clog2(CAP + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic             tick,
    input logic             gen_en,
    input logic [CNT_W-1:0] remain
);
    logic req_wr;
    assign req_wr = reg_wr && (32'(reg_addr) == OFS_REQ);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (remain == '0 && !gen_en));

    // R6
    cap_limit_chk: assert property (@(posedge clk) disable iff (rst) 32'(remain) <= CAP);

    // R7
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(req_wr) && remain != $past(remain)) |-> (32'(remain) == 32'($past(remain)) - 32'd1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!gen_en && !req_wr) |=> $stable(remain));

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

    // R11
    drained_chk: assert property (@(posedge clk) disable iff (rst)
        (remain == '0 && !req_wr) |=> remain == '0);
endmodule

bind entropy_fifo_ctrl efc_checker #(.AW(AW), .CAP(CAP)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .tick(smp_tick), .gen_en(gen_en), .remain(remain)
);

// File: tb/entropy_fifo_ctrl_tb.sv
module entropy_fifo_ctrl_tb;
    import efc_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        src_bit;
    logic        src_valid;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    entropy_fifo_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_bit(src_bit), .src_valid(src_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a[7:0]; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a[7:0];
        #1 v = reg_rdata;
    endtask

    function automatic logic pat(input int seed, input int k);
        return 1'(((k * 37 + seed * 11) >> 2) & 1);
    endfunction

    // Wait with reg_addr on the request register until the count reads target.
    task automatic wait_count(input logic [31:0] target, output int gap);
        gap = 0;
        do begin
            @(negedge clk); #1 gap++;
        end while (reg_rdata != target && gap < 5000);
    endtask

    // Driver: feeds bits, pushes expected words; monitor pops and compares.
    task automatic run_collect(input int n, input int d, input int seed, input string tag);
        int gap;
        logic [31:0] w;
        for (int wi = 0; wi < 8; wi++) begin
            w = '0;
            for (int b = 0; b < 32; b++)
                if (wi * 32 + b < n) w[b] = pat(seed, wi * 32 + b);
            exp_q.push_back(w);
        end
        src_valid = 1'b1;
        src_bit = pat(seed, 0);
        wr(OFS_REQ, n);
        for (int k = 0; k < n; k++) begin
            wait_count(n - k - 1, gap);
            if (gap >= 5000) begin
                chk({tag, " timeout"}, reg_rdata, n - k - 1);
                break;
            end
            if (k > 0) chk({tag, " tick spacing"}, gap, d);
            src_bit = pat(seed, k + 1);
        end
        for (int wi = 0; wi < 8; wi++) begin
            logic [31:0] e;
            rd(OFS_DATA + 4 * wi, w);
            e = exp_q.pop_front();
            chk("R8 word order", w, e);
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v0;
        int gap;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        src_bit = 1'b0; src_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(OFS_DIV, v);  chk("R1 div", v, 0);
        rd(OFS_CTRL, v); chk("R1 ctrl", v, 0);
        rd(OFS_POST, v); chk("R1 post", v, 0);
        rd(OFS_REQ, v);  chk("R1 req", v, 0);
        rd(OFS_DATA, v); chk("R1 data", v, 0);

        // R2 divider field, R4 control field, R5 post register
        wr(OFS_DIV, 32'hABCD_0006);  rd(OFS_DIV, v);  chk("R2 div field", v, 32'h6);
        wr(OFS_CTRL, 32'hFFFF_FFFF); rd(OFS_CTRL, v); chk("R4 ctrl field", v, 32'h8000_0000);
        wr(OFS_POST, 32'hA5A5_0F0F); rd(OFS_POST, v); chk("R5 post readback", v, 32'hA5A5_0F0F);

        // R2 spacing 6 and 5, R5 raw bits with nonzero post value
        run_collect(40, 6, 3, "R2");
        wr(OFS_DIV, 5);  run_collect(20, 5, 7, "R2");
        // R3 minimum divide
        wr(OFS_DIV, 0);  run_collect(16, 2, 2, "R3");
        wr(OFS_DIV, 1);  run_collect(16, 2, 9, "R3");

        // R10 ignored writes
        rd(OFS_DATA + 4, v0);
        wr(OFS_DATA + 4, 32'hFFFF_FFFF); rd(OFS_DATA + 4, v); chk("R10 data write ignored", v, v0);
        wr(32'h10, 32'h1234_5678); rd(32'h10, v); chk("R10 unmapped", v, 0);
        rd(32'h22, v); chk("R10 misaligned", v, 0);
        rd(32'hA0, v); chk("R10 past data", v, 0);

        // R4 generator off holds count; R6 clamp
        wr(OFS_CTRL, 0);
        wr(OFS_REQ, 8); repeat (40) @(negedge clk);
        rd(OFS_REQ, v); chk("R4 disabled hold", v, 8);
        wr(OFS_REQ, 300);        rd(OFS_REQ, v); chk("R6 clamp 300", v, 256);
        wr(OFS_REQ, 32'h10005);  rd(OFS_REQ, v); chk("R6 clamp large", v, 256);
        wr(OFS_REQ, 77);         rd(OFS_REQ, v); chk("R6 plain load", v, 77);

        // R7 strobe low stores nothing
        wr(OFS_DIV, 2); wr(OFS_CTRL, 32'h8000_0000);
        src_valid = 1'b0;
        wr(OFS_REQ, 4); repeat (30) @(negedge clk);
        rd(OFS_REQ, v); chk("R7 valid low", v, 4);
        src_valid = 1'b1; src_bit = 1'b1;
        wait_count(0, gap); chk("R7 drained", reg_rdata, 0);

        // R11 stop at zero
        rd(OFS_DATA, v0);
        repeat (40) @(negedge clk);
        rd(OFS_REQ, v);  chk("R11 stays zero", v, 0);
        rd(OFS_DATA, v); chk("R11 data kept", v, v0);
        chk("R11 four ones", v0, 32'hF);

        // Full capacity, all words
        run_collect(256, 2, 5, "R2");

        // R9 request write coinciding with a tick
        wr(OFS_DIV, 4);
        src_valid = 1'b1; src_bit = 1'b1;
        wr(OFS_REQ, 40);
        wait_count(39, gap);
        repeat (3) @(negedge clk);
        reg_wr = 1'b1; reg_addr = OFS_REQ[7:0]; reg_wdata = 10;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk("R9 write wins count", reg_rdata, 10);
        rd(OFS_DATA, v); chk("R9 words cleared", v, 0);
        reg_addr = OFS_REQ[7:0];
        wait_count(9, gap);
        rd(OFS_DATA, v); chk("R9 restart at bit0", v, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule